// File: doc/BRIEF.md
# LFSR Random Source with CRC16 Engine

This block holds one 16-bit shift register that serves two purposes. As a random source, a host seeds it one byte at a time through a low-byte register and advances it with a single-cycle step pulse; each step applies one Galois feedback step. As a checksum engine, each byte the host writes to the high-byte register is folded into the register as a CRC16, one bit per clock, most significant bit first. The running value is then read back through the same two byte registers.

Each byte register has a write enable, write data, a read enable and registered read data. A high-byte write makes the engine busy for eight cycles. While it is busy, writes and step pulses are dropped. When several operations are requested in the same idle cycle, only the highest-priority one takes effect.

Top module: `lfsr_crc16`

## Requirements
- R1: After reset, the register holds 0xFFFF: a read of either byte returns 0xFF, and `busy` is low.
- R2: An idle low-byte write (no high-byte write in the same cycle) moves register bits 7:0 into bits 15:8 and loads the written byte into bits 7:0.
- R3: Two back-to-back idle low-byte writes, first A then B, leave the register equal to {A, B}.
- R4: A read enable captures the byte at the clock edge where it is sampled: bits 7:0 for the low register, bits 15:8 for the high register. The value appears on the read data port after that edge and holds until the next read enable.
- R5: An idle high-byte write folds the byte into the register as a CRC16. The polynomial is 0x8005 (x^16+x^15+x^2+1), the byte is taken MSB first, with no reflection and no final XOR. The CRC starts from the current register value. For example, seed 0x0000 over the ASCII string "123456789" gives 0xFEE8, and seed 0xFFFF over the same string gives 0xAEE7.
- R6: `busy` rises at the edge that accepts a high-byte write and stays high for exactly eight cycles, one bit being processed per cycle.
- R7: Low-byte and high-byte writes made while `busy` is high are ignored.
- R8: An idle step pulse applies one Galois step: the register shifts left by one with a 0 entering, then XORs in 0x8005 if the old bit 15 was 1. For example, 0xFFFF becomes 0x7FFB.
- R9: Step pulses while `busy` is high are ignored.
- R10: In an idle cycle, a high-byte write takes precedence over a low-byte write, and a low-byte write takes precedence over a step. The lower-priority request in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lo_we | input | 1 | Low-byte register write enable (seed shift) |
| lo_wdata | input | 8 | Low-byte write data |
| lo_re | input | 1 | Low-byte register read enable |
| lo_rdata | output | 8 | Registered low-byte read data |
| hi_we | input | 1 | High-byte register write enable (CRC byte) |
| hi_wdata | input | 8 | High-byte write data |
| hi_re | input | 1 | High-byte register read enable |
| hi_rdata | output | 8 | Registered high-byte read data |
| step | input | 1 | Advance the random sequence by one step |
| busy | output | 1 | CRC byte in progress |

## Verification
The CRC is checked with the standard nine-byte check string from two different seeds. Its known answers separate a wrong polynomial, wrong bit order and a wrong start value. Single steps from 0xFFFF, and byte seeding with different values, show whether the shift direction and byte placement are right. Writes and steps issued during a busy window, and several requests issued in the same idle cycle, show whether gating and priority work. A behavioural model compared every cycle catches any difference in timing.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_CRC  = 2'd1,
    OP_SEED = 2'd2,
    OP_STEP = 2'd3
  } lfsr_op_e;
endpackage

// File: rtl/lfsr_crc_bitstep.sv
module lfsr_crc_bitstep #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8005
) (
  input  logic [W-1:0] cur_i,
  input  logic         din_i,
  output logic [W-1:0] nxt_o
);
  logic fb;

  always_comb begin
    fb    = cur_i[W-1] ^ din_i;
    nxt_o = {cur_i[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
endmodule

// File: rtl/lfsr_crc_seq.sv
module lfsr_crc_seq #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [BITS-1:0] byte_i,
  output logic            busy_o,
  output logic            bit_o
);
  localparam int CNT_W = $clog2(BITS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BITS-1:0]  buf_q, buf_d;
  logic             start;
  logic             en;

  assign busy_o = (cnt_q != '0);
  assign bit_o  = buf_q[BITS-1];
  assign start  = we_i && !busy_o;
  assign en     = start || busy_o;

  always_comb begin
    cnt_d = cnt_q;
    buf_d = buf_q;
    if (start) begin
      cnt_d = CNT_W'(BITS);
      buf_d = byte_i;
    end else if (busy_o) begin
      cnt_d = cnt_q - 1'b1;
      buf_d = {buf_q[BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      buf_q <= buf_d;
    end
  end

  // R7: a write during a busy window must not reload the bit counter
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && we_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6: counter never exceeds one byte of bits
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BITS));

  // R6: an accepted write starts a full window
  a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_o && cnt_q == CNT_W'(BITS)));
endmodule

// File: rtl/lfsr_crc16.sv
module lfsr_crc16 #(
  parameter int              W      = 16,
  parameter int              BYTE   = 8,
  parameter logic [W-1:0]    POLY   = 16'h8005,
  parameter logic [W-1:0]    INIT   = 16'hFFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_we,
  input  logic [BYTE-1:0] lo_wdata,
  input  logic            lo_re,
  output logic [BYTE-1:0] lo_rdata,
  input  logic            hi_we,
  input  logic [BYTE-1:0] hi_wdata,
  input  logic            hi_re,
  output logic [BYTE-1:0] hi_rdata,
  input  logic            step,
  output logic            busy
);
  import lfsr_crc_pkg::*;

  localparam int HI_LSB = W - BYTE;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [W-1:0]    state_q, state_d, step_nxt;
  logic [BYTE-1:0] lo_rd_q, hi_rd_q;
  lfsr_op_e        op;
  logic            crc_bit, step_din;

  // Reset: asserted asynchronously, released on clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lfsr_crc_seq #(.BITS(BYTE)) u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_i   (hi_we),
    .byte_i (hi_wdata),
    .busy_o (busy),
    .bit_o  (crc_bit)
  );

  // Operation select: busy > high write > low write > step
  always_comb begin
    if (busy)        op = OP_CRC;
    else if (hi_we)  op = OP_HOLD;
    else if (lo_we)  op = OP_SEED;
    else if (step)   op = OP_STEP;
    else             op = OP_HOLD;
  end

  assign step_din = (op == OP_CRC) ? crc_bit : 1'b0;

  lfsr_crc_bitstep #(.W(W), .POLY(POLY)) u_step (
    .cur_i (state_q),
    .din_i (step_din),
    .nxt_o (step_nxt)
  );

  always_comb begin
    unique case (op)
      OP_CRC,
      OP_STEP: state_d = step_nxt;
      OP_SEED: state_d = {state_q[BYTE-1:0], lo_wdata};
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        state_q <= INIT;
    else if (op != OP_HOLD) state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  lo_rd_q <= INIT[BYTE-1:0];
    else if (lo_re)  lo_rd_q <= state_q[BYTE-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  hi_rd_q <= INIT[W-1:HI_LSB];
    else if (hi_re)  hi_rd_q <= state_q[W-1:HI_LSB];
  end

  assign lo_rdata = lo_rd_q;
  assign hi_rdata = hi_rd_q;

  // R2: idle low write shifts the old low byte up
  a_r2_low_shift: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lo_we && !hi_we && !busy) |=>
      (state_q[W-1:HI_LSB] == $past(state_q[BYTE-1:0]) &&
       state_q[BYTE-1:0] == $past(lo_wdata)));

  // R10: high write in an idle cycle leaves the register untouched that cycle
  a_r10_hi_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hi_we && !busy) |=> (state_q == $past(state_q)));

  // R4: read data holds the byte seen at the read edge
  a_r4_lo_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    lo_re |=> (lo_rdata == $past(state_q[BYTE-1:0])));

  a_r4_hi_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !hi_re |=> $stable(hi_rdata));
endmodule

// File: tb/test_lfsr_crc16.sv
module test_lfsr_crc16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lo_we = 1'b0, lo_re = 1'b0, hi_we = 1'b0, hi_re = 1'b0, step = 1'b0;
  logic [7:0] lo_wdata = 8'h00, hi_wdata = 8'h00;
  logic [7:0] lo_rdata, hi_rdata;
  logic       busy;

  int errors = 0;
  int checks = 0;
  bit live   = 1'b0;
  bit done   = 1'b0;

  // reference model state
  logic [15:0] m_state;
  logic [7:0]  m_lo, m_hi;
  int          m_cnt;
  bit          m_bits[$];

  always #10 clk = ~clk;

  lfsr_crc16 i_lfsr_crc16 (
    .clk(clk), .rst_n(rst_n),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .lo_re(lo_re), .lo_rdata(lo_rdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .hi_re(hi_re), .hi_rdata(hi_rdata),
    .step(step), .busy(busy)
  );

  function automatic logic [15:0] galois(input logic [15:0] s, input bit d);
    bit fb;
    fb = s[15] ^ d;
    s  = s << 1;
    if (fb) s = s ^ 16'h8005;
    return s;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    logic [15:0] s;
    if (!rst_n) begin
      m_state = 16'hFFFF; m_lo = 8'hFF; m_hi = 8'hFF; m_cnt = 0; m_bits.delete();
    end else begin
      s = m_state;
      if (lo_re) m_lo = s[7:0];
      if (hi_re) m_hi = s[15:8];
      if (m_cnt != 0) begin
        m_state = galois(s, m_bits.pop_front());
        m_cnt--;
      end else if (hi_we) begin
        for (int i = 7; i >= 0; i--) m_bits.push_back(hi_wdata[i]);
        m_cnt = 8;
      end else if (lo_we) begin
        m_state = {s[7:0], lo_wdata};
      end else if (step) begin
        m_state = galois(s, 1'b0);
      end
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (live && !done) begin
      check("R4 lo_rdata vs model", lo_rdata, m_lo);
      check("R4 hi_rdata vs model", hi_rdata, m_hi);
      check("R6 busy vs model", busy, (m_cnt != 0));
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_lo(input logic [7:0] b);
    lo_we = 1'b1; lo_wdata = b; tick(); lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] b);
    hi_we = 1'b1; hi_wdata = b; tick(); hi_we = 1'b0;
    repeat (8) tick();
  endtask

  task automatic rd(output logic [15:0] v);
    lo_re = 1'b1; hi_re = 1'b1; tick(); lo_re = 1'b0; hi_re = 1'b0;
    v = {hi_rdata, lo_rdata};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    string txt;
    txt = "123456789";
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    live = 1'b1;

    // R1 reset value
    check("R1 busy after reset", busy, 0);
    rd(v);
    check("R1 reset value", v, 16'hFFFF);

    // R8 single step
    step = 1'b1; tick(); step = 1'b0;
    rd(v);
    check("R8 step from FFFF", v, 16'h7FFB);

    // R2 low write
    wr_lo(8'h12);
    rd(v);
    check("R2 low write shift", v, 16'hFB12);

    // R3 two-byte seed, then R5 known answer from 0
    wr_lo(8'h00); wr_lo(8'h00);
    rd(v);
    check("R3 seed 0000", v, 16'h0000);
    wr_lo(8'hA5); wr_lo(8'h3C);
    rd(v);
    check("R3 seed A53C", v, 16'hA53C);
    wr_lo(8'h00); wr_lo(8'h00);

    // R6 busy window length on first byte
    hi_we = 1'b1; hi_wdata = txt[0]; tick(); hi_we = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check("R6 busy during byte", busy, 1);
      tick();
    end
    check("R6 busy low after 8", busy, 0);
    for (int i = 1; i < 9; i++) wr_hi(txt[i]);
    rd(v);
    check("R5 crc seed 0000", v, 16'hFEE8);

    // R5 from FFFF
    wr_lo(8'hFF); wr_lo(8'hFF);
    for (int i = 0; i < 9; i++) wr_hi(txt[i]);
    rd(v);
    check("R5 crc seed FFFF", v, 16'hAEE7);

    // R7/R9: requests during busy are dropped
    wr_lo(8'h00); wr_lo(8'h00);
    hi_we = 1'b1; hi_wdata = 8'h31; tick(); hi_we = 1'b0;
    tick();
    lo_we = 1'b1; lo_wdata = 8'h55; tick(); lo_we = 1'b0;
    hi_we = 1'b1; hi_wdata = 8'hAA; tick(); hi_we = 1'b0;
    step = 1'b1; tick(); tick(); step = 1'b0;
    repeat (4) tick();
    check("R7 busy done", busy, 0);
    rd(v);
    check("R7 R9 only first byte absorbed", v, galois(galois(galois(galois(
      galois(galois(galois(galois(16'h0000,0),0),1),1),0),0),0),1));

    // R10 priority: high over low and step
    wr_lo(8'h00); wr_lo(8'h00);
    hi_we = 1'b1; lo_we = 1'b1; step = 1'b1; hi_wdata = txt[0]; lo_wdata = 8'h77;
    tick(); hi_we = 1'b0; lo_we = 1'b0; step = 1'b0;
    repeat (8) tick();
    for (int i = 1; i < 9; i++) wr_hi(txt[i]);
    rd(v);
    check("R10 high write wins", v, 16'hFEE8);
    // low over step
    lo_we = 1'b1; step = 1'b1; lo_wdata = 8'h9C; tick(); lo_we = 1'b0; step = 1'b0;
    rd(v);
    check("R10 low write wins over step", v, 16'hE89C);

    // R8 run of steps against model
    repeat (20) begin step = 1'b1; tick(); end
    step = 1'b0;
    rd(v);
    check("R8 step run vs model", v, m_state);

    tick();
    finish_run();
  end
endmodule